// File: doc/BRIEF.md
# Row-Scanned Shared-Converter Time-of-Flight Readout

This block is the digital sequencer and datapath of a direct time-of-flight photon-timing array. A host command starts a frame. The block then visits the rows of the array one after another. For each row it clears its converters and raises `ready_o`. It then waits for the host to fire the laser, and times the photon returns of that row on a small bank of shared time-to-digital converters. Finally it streams the results out, one word per clock.

Every four adjacent columns of the active row form a group, and each group owns one converter. The first pixel in a group whose photon pulse rises stops that converter, which then ignores the other three pixels until the next row shot. The pulses arrive already quenched and digitised, and the array routes the active row onto `hit_i` according to `row_sel_o`. The converter has two segments. A coarse segment counts reference clocks. A fine segment records which of several phase-shifted clocks had just risen at the stop. Together they extend the resolution below one clock period without a faster clock.

Top module: `tofro_top`

## Requirements
- R1: After reset, `ready_o`, `laser_en_o`, `dout_vld_o` and `frame_done_o` are low, and `row_sel_o` and `dout_o` are zero.
- R2: A `start_i` pulse while idle begins a frame at row 0. `ready_o` is low in the next cycle and high in the cycle after that. A `start_i` pulse at any other time has no effect.
- R3: `laser_go_i` sampled while `ready_o` is high makes `laser_en_o` high for exactly the next cycle and drops `ready_o`. `laser_go_i` at any other time leaves `laser_en_o` low.
- R4: A hit whose input first goes high during cycle k after the rise of `laser_en_o` (k=0 being the cycle in which `laser_en_o` is high) reports coarse code k+2. The fine code comes from `phase_i` as sampled on the same clock edge as that hit. It is the lowest index i for which phase bit i is 1 and the bit below it (bit 3 for i=0) is 0, or 0 if there is no such index.
- R5: Each result word is 15 bits: bit 14 is the valid flag, bits 13:12 are the pixel index (column mod 4), bits 11:2 are the coarse code and bits 1:0 are the fine code. Group g covers columns 4g to 4g+3.
- R6: Once a group has stopped, later rising hits from any pixel of that group leave its word unchanged until the next row shot.
- R7: When several pixels of a group rise in the same cycle, the lowest pixel index wins.
- R8: A group with no hit when the coarse count reaches 1023 reports 0x0FFF (valid clear). A hit detected in that same final cycle is still reported as valid, with coarse code 1023.
- R9: Timing ends once every group has stopped, or when the count reaches 1023. The first word then appears 3 cycles after the last stop (1025 cycles after `laser_en_o` when saturation ends the window). Words follow group by group on consecutive cycles with `dout_vld_o` high, and rows are served in ascending order through `row_sel_o`.
- R10: `frame_done_o` is high for one cycle, together with the last word of the last row. The block then returns to idle and raises `ready_o` again only after a new `start_i`.
- R11: A hit input that is already high before the laser shot and stays high never stops a converter. Only a rising edge during the timing window counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Host command to begin a frame |
| laser_go_i | input | 1 | Host request to fire the laser for the current row |
| hit_i | input | COLS | Digitised photon pulses of the active row |
| phase_i | input | PH | Snapshot of the phase-shifted clocks |
| ready_o | output | 1 | Row cleared and waiting for the laser shot |
| laser_en_o | output | 1 | One-cycle laser strobe; timing starts with it |
| row_sel_o | output | $clog2(ROWS) | Row currently served |
| dout_o | output | 15 | Result word of one group |
| dout_vld_o | output | 1 | `dout_o` holds a word |
| frame_done_o | output | 1 | Last word of the frame |

## Verification
Two events can meet in a single cycle. The first is a photon stop arriving in the very cycle the coarse counter saturates. That case is provoked by driving a hit 1021 cycles after the laser strobe, and it is judged by expecting a valid word with coarse code 1023 beside an overflow word for the idle group. The second is two pixels of one group rising together, which must resolve to the lower index. A table of row shots covers distinct arrival times, phase patterns, lock-out and early window closing. Each shot's words and the cycle of the first word are checked against values computed from the requirements.

// File: rtl/tofro_pkg.sv
package tofro_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_ARM,
        ST_TIME,
        ST_READ
    } tof_state_e;

endpackage

// File: rtl/tofro_sync.sv
module tofro_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] rise_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign rise_o = sync_q.s2 & ~sync_q.s3;

    // a level that stays high yields a single-cycle edge (R11)
    p_rise_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/tofro_grp.sv
module tofro_grp #(
    parameter int unsigned PIX = 4,
    parameter int unsigned CW  = 10,
    parameter int unsigned PH  = 4,
    localparam int unsigned PW = $clog2(PIX),
    localparam int unsigned FW = $clog2(PH)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           clear_i,
    input  logic           run_i,
    input  logic           sat_i,
    input  logic [PIX-1:0] rise_i,
    input  logic [CW-1:0]  coarse_i,
    input  logic [PH-1:0]  phase_i,
    output logic           locked_o,
    output logic           hit_o,
    output logic [PW-1:0]  pix_o,
    output logic [CW-1:0]  coarse_o,
    output logic [FW-1:0]  fine_o
);

    typedef struct packed {
        logic          locked;
        logic          hit;
        logic [PW-1:0] pix;
        logic [CW-1:0] coarse;
        logic [FW-1:0] fine;
    } grp_t;

    grp_t grp_d, grp_q;
    logic [PW-1:0] first_pix;
    logic [FW-1:0] fine_enc;

    always_comb begin
        first_pix = '0;
        for (int i = PIX - 1; i >= 0; i--) begin
            if (rise_i[i]) first_pix = PW'(i);
        end
        fine_enc = '0;
        for (int i = PH - 1; i >= 0; i--) begin
            if (phase_i[i] && !phase_i[(i + PH - 1) % PH]) fine_enc = FW'(i);
        end
    end

    always_comb begin
        grp_d = grp_q;
        if (clear_i) begin
            grp_d = '0;
        end else if (run_i && !grp_q.locked) begin
            if (|rise_i) begin
                grp_d.locked = 1'b1;
                grp_d.hit    = 1'b1;
                grp_d.pix    = first_pix;
                grp_d.coarse = coarse_i;
                grp_d.fine   = fine_enc;
            end else if (sat_i) begin
                grp_d.locked = 1'b1;
                grp_d.hit    = 1'b0;
                grp_d.pix    = '0;
                grp_d.coarse = '1;
                grp_d.fine   = '1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) grp_q <= '0;
        else         grp_q <= grp_d;
    end

    assign locked_o = grp_q.locked;
    assign hit_o    = grp_q.hit;
    assign pix_o    = grp_q.pix;
    assign coarse_o = grp_q.coarse;
    assign fine_o   = grp_q.fine;

    // a stopped converter keeps its result until the next clear (R6)
    p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && !clear_i) |=> (locked_o && $stable({hit_o, pix_o, coarse_o, fine_o})));

    // an edge while running and unlocked produces a valid result (R4)
    p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !locked_o && !clear_i && (|rise_i)) |=> (hit_o && locked_o));

    // saturation without an edge yields the no-hit code (R8)
    p_sat_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && sat_i && !locked_o && !clear_i && !(|rise_i)) |=> (!hit_o && (coarse_o == '1)));

endmodule

// File: rtl/tofro_top.sv
module tofro_top
    import tofro_pkg::*;
#(
    parameter int unsigned ROWS = 4,
    parameter int unsigned COLS = 8,
    parameter int unsigned PIX  = 4,
    parameter int unsigned CW   = 10,
    parameter int unsigned PH   = 4,
    localparam int unsigned NG  = COLS / PIX,
    localparam int unsigned RW  = $clog2(ROWS),
    localparam int unsigned GW  = $clog2(NG > 1 ? NG : 2),
    localparam int unsigned PW  = $clog2(PIX),
    localparam int unsigned FW  = $clog2(PH),
    localparam int unsigned WW  = 1 + PW + CW + FW
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            start_i,
    input  logic            laser_go_i,
    input  logic [COLS-1:0] hit_i,
    input  logic [PH-1:0]   phase_i,
    output logic            ready_o,
    output logic            laser_en_o,
    output logic [RW-1:0]   row_sel_o,
    output logic [WW-1:0]   dout_o,
    output logic            dout_vld_o,
    output logic            frame_done_o
);

    localparam logic [CW-1:0] CMAX = '1;

    typedef struct packed {
        tof_state_e    st;
        logic [RW-1:0] row;
        logic [GW-1:0] gsel;
        logic [CW-1:0] coarse;
        logic          laser;
        logic [WW-1:0] dout;
        logic          vld;
        logic          done;
        logic [PH-1:0] ph1;
        logic [PH-1:0] ph2;
    } top_t;

    top_t top_d, top_q;

    logic [COLS-1:0] rise;
    logic [NG-1:0]   locked;
    logic [WW-1:0]   grp_word [NG];
    logic            grp_clear, grp_run, grp_sat;

    assign grp_clear = (top_q.st == ST_CLR);
    assign grp_run   = (top_q.st == ST_TIME);
    assign grp_sat   = grp_run && (top_q.coarse == CMAX);

    tofro_sync #(.W(COLS)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (hit_i),
        .rise_o  (rise)
    );

    for (genvar g = 0; g < NG; g++) begin : g_grp
        logic          w_hit;
        logic [PW-1:0] w_pix;
        logic [CW-1:0] w_coarse;
        logic [FW-1:0] w_fine;

        tofro_grp #(.PIX(PIX), .CW(CW), .PH(PH)) u_grp (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .clear_i  (grp_clear),
            .run_i    (grp_run),
            .sat_i    (grp_sat),
            .rise_i   (rise[g*PIX +: PIX]),
            .coarse_i (top_q.coarse),
            .phase_i  (top_q.ph2),
            .locked_o (locked[g]),
            .hit_o    (w_hit),
            .pix_o    (w_pix),
            .coarse_o (w_coarse),
            .fine_o   (w_fine)
        );

        assign grp_word[g] = {w_hit, w_pix, w_coarse, w_fine};
    end

    always_comb begin
        top_d       = top_q;
        top_d.laser = 1'b0;
        top_d.vld   = 1'b0;
        top_d.done  = 1'b0;
        top_d.ph1   = phase_i;
        top_d.ph2   = top_q.ph1;
        case (top_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    top_d.st  = ST_CLR;
                    top_d.row = '0;
                end
            end
            ST_CLR: top_d.st = ST_ARM;
            ST_ARM: begin
                if (laser_go_i) begin
                    top_d.st     = ST_TIME;
                    top_d.coarse = '0;
                    top_d.laser  = 1'b1;
                end
            end
            ST_TIME: begin
                if (top_q.coarse != CMAX) top_d.coarse = top_q.coarse + 1'b1;
                if ((&locked) || (top_q.coarse == CMAX)) begin
                    top_d.st   = ST_READ;
                    top_d.gsel = '0;
                end
            end
            ST_READ: begin
                top_d.dout = grp_word[top_q.gsel];
                top_d.vld  = 1'b1;
                if (top_q.gsel == GW'(NG - 1)) begin
                    if (top_q.row == RW'(ROWS - 1)) begin
                        top_d.st   = ST_IDLE;
                        top_d.done = 1'b1;
                    end else begin
                        top_d.st  = ST_CLR;
                        top_d.row = top_q.row + 1'b1;
                    end
                end else begin
                    top_d.gsel = top_q.gsel + 1'b1;
                end
            end
            default: top_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            top_q    <= '0;
            top_q.st <= ST_IDLE;
        end else begin
            top_q <= top_d;
        end
    end

    assign ready_o      = (top_q.st == ST_ARM);
    assign laser_en_o   = top_q.laser;
    assign row_sel_o    = top_q.row;
    assign dout_o       = top_q.dout;
    assign dout_vld_o   = top_q.vld;
    assign frame_done_o = top_q.done;

    // laser strobe lasts one cycle (R3)
    p_laser_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        laser_en_o |=> !laser_en_o);

    // laser strobe only follows a request taken while ready (R3)
    p_laser_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        laser_en_o |-> $past(ready_o && laser_go_i));

    // ready persists until the shot is requested (R2)
    p_ready_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && !laser_go_i) |=> ready_o);

    // frame end coincides with a delivered word (R10)
    p_done_word_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_o |-> (dout_vld_o && (row_sel_o == RW'(ROWS - 1))));

    // frame end is a single-cycle pulse (R10)
    p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_o |=> !frame_done_o);

endmodule

// File: tb/tb_tofro_top.sv
`timescale 1ns/1ps
module tb_tofro_top;

    localparam int ROWS = 4;
    localparam int COLS = 8;
    localparam int NG   = 2;
    localparam logic [10:0] NONE = 11'h7FF;

    // {colA, dlyA, phA, colB, dlyB, phB}
    localparam logic [37:0] VEC [8] = '{
        {4'd0, 11'd0,    4'b0011, 4'd5, 11'd10,  4'b0110},
        {4'd3, 11'd100,  4'b1100, 4'd7, 11'd37,  4'b1001},
        {4'd2, 11'd7,    4'b0011, 4'd1, 11'd7,   4'b0011},
        {4'd2, 11'd3,    4'b0110, 4'd1, 11'd5,   4'b1100},
        {4'd6, 11'd1021, 4'b1100, 4'd0, NONE,    4'b0000},
        {4'd0, NONE,     4'b0000, 4'd0, NONE,    4'b0000},
        {4'd4, 11'd20,   4'b0000, 4'd0, 11'd500, 4'b1001},
        {4'd5, 11'd2,    4'b0110, 4'd6, 11'd2,   4'b0110}
    };
    localparam string TAG [8] = '{"R4 R5", "R4 R5", "R7", "R6", "R8", "R8", "R4", "R7"};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            go = 1'b0;
    logic [COLS-1:0] hit = '0;
    logic [3:0]      phase = '0;
    logic            ready, laser_en, vld, done;
    logic [1:0]      row_sel;
    logic [14:0]     dout;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tofro_top dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .laser_go_i   (go),
        .hit_i        (hit),
        .phase_i      (phase),
        .ready_o      (ready),
        .laser_en_o   (laser_en),
        .row_sel_o    (row_sel),
        .dout_o       (dout),
        .dout_vld_o   (vld),
        .frame_done_o (done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] enc(input logic [3:0] p);
        for (int i = 0; i < 4; i++) begin
            if (p[i] && !p[(i + 3) % 4]) return 2'(i);
        end
        return 2'd0;
    endfunction

    // winner of group g: returns delay (-1 if none), column and phase
    task automatic winner(input int g, input logic [37:0] v,
                          output int bd, output int bc, output logic [3:0] bp);
        bd = -1; bc = 0; bp = '0;
        if (v[33:23] != NONE && int'(v[37:34]) / 4 == g) begin
            bd = int'(v[33:23]); bc = int'(v[37:34]); bp = v[22:19];
        end
        if (v[14:4] != NONE && int'(v[18:15]) / 4 == g) begin
            if (bd < 0 || int'(v[14:4]) < bd || (int'(v[14:4]) == bd && int'(v[18:15]) < bc)) begin
                bd = int'(v[14:4]); bc = int'(v[18:15]); bp = v[3:0];
            end
        end
    endtask

    task automatic run_shot(input logic [37:0] v, input logic [COLS-1:0] held,
                            input int row, input bit last, input string tag);
        int k;
        int expk;
        int maxc;
        bit ov;
        int bd, bc;
        logic [3:0] bp;
        logic [14:0] ew;
        while (!ready) @(negedge clk);
        chk("R9 row order", 32'(row_sel), 32'(row));
        hit = held;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 start ignored while busy", 32'(ready), 1);
        chk("R2 row unchanged", 32'(row_sel), 32'(row));
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk("R3 laser strobe", 32'(laser_en), 1);
        chk("R3 ready drops", 32'(ready), 0);
        k = 0;
        while (!vld) begin
            if (k == 1) chk("R3 strobe one cycle", 32'(laser_en), 0);
            if (v[33:23] == 11'(k)) begin hit[v[37:34]] = 1'b1; phase = v[22:19]; end
            if (v[14:4]  == 11'(k)) begin hit[v[18:15]] = 1'b1; phase = v[3:0]; end
            @(negedge clk);
            k++;
        end
        ov = 1'b0; maxc = 0;
        for (int g = 0; g < NG; g++) begin
            winner(g, v, bd, bc, bp);
            if (bd < 0) ov = 1'b1;
            else if (bd + 2 > maxc) maxc = bd + 2;
        end
        expk = (ov || maxc == 1023) ? 1025 : maxc + 3;
        chk("R9 first word cycle", 32'(k), 32'(expk));
        for (int g = 0; g < NG; g++) begin
            winner(g, v, bd, bc, bp);
            if (bd < 0) ew = 15'h0FFF;
            else ew = {1'b1, 2'(bc % 4), 10'(bd + 2), enc(bp)};
            chk({tag, " word"}, 32'(dout), 32'(ew));
            chk("R9 word valid", 32'(vld), 1);
            chk("R10 frame done", 32'(done), 32'(last && g == NG - 1));
            @(negedge clk);
        end
        chk("R9 stream ends", 32'(vld), 0);
        hit = '0;
    endtask

    task automatic start_frame();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 clear cycle", 32'(ready), 0);
        @(negedge clk);
        chk("R2 ready", 32'(ready), 1);
        chk("R2 row zero", 32'(row_sel), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R9: actual hung expected frame end");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 ready", 32'(ready), 0);
        chk("R1 laser", 32'(laser_en), 0);
        chk("R1 valid", 32'(vld), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 row", 32'(row_sel), 0);
        chk("R1 data", 32'(dout), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // laser request while idle is ignored
        go = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3 no strobe when idle", 32'(laser_en), 0);
        end
        go = 1'b0;

        // table of row shots, two frames
        for (int i = 0; i < 8; i++) begin
            if (i % 4 == 0) start_frame();
            run_shot(VEC[i], '0, i % 4, (i % 4) == 3, TAG[i]);
            if (i % 4 == 3) begin
                repeat (3) @(negedge clk);
                chk("R10 back to idle", 32'(ready), 0);
            end
        end

        // held input before the shot never stops a converter
        start_frame();
        run_shot({4'd0, 11'd4, 4'b0011, 4'd0, NONE, 4'b0000}, 8'h10, 0, 1'b0, "R11");
        for (int r = 1; r < ROWS; r++) begin
            run_shot({4'd0, NONE, 4'b0000, 4'd0, NONE, 4'b0000}, '0, r, r == ROWS - 1, "R8");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule